// File: doc/BRIEF.md
# Synapse Packet Stream Emitter

This block turns wide synapse-list words into a narrow stream of synapse packets for neurons that have fired. Each 256-bit input word holds four 64-bit packets. The block hands them out one per output handshake, lowest lane first. The first word of a neuron arrives with a start flag and the neuron's packet count. The count sets how many further words belong to that neuron and how many lanes of the last word carry real packets. Lanes beyond the count are discarded.

Once a neuron's packets have all gone out, the block inserts a local synchronization token so that downstream logic can tell where one neuron's traffic ends. A one-cycle end-of-timestep request is remembered until no neuron is in progress. The block then emits a global synchronization token before it accepts the next neuron. Both tokens reuse the packet format and are told apart by the packet's 2-bit sync field.

Top module: `synpkt_emitter`

## Requirements
- R1: Packet layout is weight[63:32], sync[31:30], destination[29:8], delay[7:0]. Lane k of a word is bits [64k+63:64k], and lanes are emitted in rising k order. Data packets leave with sync forced to 2'b00 and every other bit unchanged. The first packet is valid in the cycle after the word is accepted, and later packets follow one per accepted output cycle.
- R2: A neuron with count N emits exactly N data packets taken from max(1, ceil(N/4)) input words. Lanes past N in the last word are dropped. A count of zero consumes one word and emits only the local token.
- R3: After a neuron's last data packet, the next output is a local token 64'h0000_0000_4000_0000 (sync 2'b01, all other bits zero). It is valid in the cycle after the last data handshake, and only one is emitted per neuron.
- R4: A pulse on tstep_end makes the block emit a global token 64'h0000_0000_8000_0000 (sync 2'b10, all other bits zero). The token waits until any neuron in progress has emitted its data and its local token. It goes out before the next neuron's word is accepted. When the block is idle, the token is valid in the cycle after the edge that samples the pulse.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R6: in_ready is high only when every lane of the previous word has been consumed and no token is waiting. in_ready and out_valid are never high together.
- R7: A word accepted while no neuron is in progress and with in_first low is dropped and produces no output.
- R8: After reset, out_valid is low, in_ready is high and no global token is pending.
- R9: While a neuron still expects words, in_first and in_count on an incoming word are ignored. That word is taken as a continuation of the current neuron.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | Wide word can be taken |
| in_data | input | 256 | Four packed synapse packets |
| in_first | input | 1 | Word starts a new neuron |
| in_count | input | CNT_W | Packet count of the new neuron, read with in_first |
| tstep_end | input | 1 | One-cycle request for a global token |
| out_valid | output | 1 | Packet or token offered |
| out_ready | input | 1 | Downstream takes the offered packet |
| out_data | output | 64 | Synapse packet or sync token |

## Verification
A word accepted at edge k yields its first packet valid after edge k. With out_ready held high, the remaining packets follow at k+1 onward and the local token becomes valid right after the last data handshake. A tstep_end pulse sampled at an idle edge yields a valid global token one cycle later. The bench drives inputs and reads outputs on falling edges and probes exactly those cycles in directed cases. A queue model then checks every output handshake in order under both a steady and an irregular out_ready pattern, and it checks the hold rule whenever a packet has been stalled.

// File: rtl/synpkt_pkg.sv
package synpkt_pkg;

  localparam int PKT_W   = 64;
  localparam int SYNC_LO = 30;
  localparam int SYNC_HI = 31;

  typedef enum logic [1:0] {
    SYNC_DATA   = 2'b00,
    SYNC_LOCAL  = 2'b01,
    SYNC_GLOBAL = 2'b10
  } sync_code_e;

  // Token packet: only the sync field is non-zero.
  function automatic logic [PKT_W-1:0] make_token(sync_code_e code);
    logic [PKT_W-1:0] t;
    t = '0;
    t[SYNC_HI:SYNC_LO] = code;
    return t;
  endfunction

  // Data packet leaves with its sync field marked as ordinary data.
  function automatic logic [PKT_W-1:0] scrub_data(logic [PKT_W-1:0] p);
    logic [PKT_W-1:0] r;
    r = p;
    r[SYNC_HI:SYNC_LO] = SYNC_DATA;
    return r;
  endfunction

  // Packets to place in one wide word, given how many are still owed.
  function automatic int unsigned lanes_take(int unsigned owed, int unsigned lanes);
    return (owed < lanes) ? owed : lanes;
  endfunction

endpackage

// File: rtl/synpkt_slot_buf.sv
module synpkt_slot_buf #(
  parameter int LANES = 4,
  parameter int PKT_W = 64,
  localparam int WORD_W = LANES * PKT_W,
  localparam int SLOT_W = $clog2(LANES + 1),
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [SLOT_W-1:0] load_slots,
  input  logic              pop,
  output logic [SLOT_W-1:0] slots_left,
  output logic [PKT_W-1:0]  cur_pkt
);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] left_q;
  logic [PKT_W-1:0]  lane_pkt [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_pkt[g] = word_q[g*PKT_W +: PKT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      word_q <= load_word;
      idx_q  <= '0;
      left_q <= load_slots;
    end else if (pop) begin
      idx_q  <= idx_q + IDX_W'(1);
      left_q <= left_q - SLOT_W'(1);
    end
  end

  assign slots_left = left_q;
  assign cur_pkt    = lane_pkt[idx_q];

endmodule

// File: rtl/synpkt_neuron_trk.sv
module synpkt_neuron_trk
  import synpkt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 12,
  localparam int SLOT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              local_done,
  input  logic              glob_req,
  input  logic              glob_done,
  output logic              in_neuron,
  output logic              more_words,
  output logic              glob_pend,
  output logic [SLOT_W-1:0] load_slots
);

  logic [CNT_W-1:0] rem_q;
  logic             nrn_q;
  logic             gpend_q;
  logic [CNT_W-1:0] owed;

  // Packets still owed: the running remainder, or the new neuron's count.
  always_comb begin
    if (nrn_q)      owed = rem_q;
    else if (start) owed = count;
    else            owed = '0;
    load_slots = SLOT_W'(lanes_take(int'(owed), LANES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      nrn_q <= 1'b0;
    end else if (accept) begin
      if (nrn_q || start) begin
        rem_q <= owed - CNT_W'(load_slots);
        nrn_q <= 1'b1;
      end
    end else if (local_done) begin
      nrn_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gpend_q <= 1'b0;
    else if (glob_req)  gpend_q <= 1'b1;
    else if (glob_done) gpend_q <= 1'b0;
  end

  assign in_neuron  = nrn_q;
  assign more_words = (rem_q != '0);
  assign glob_pend  = gpend_q;

endmodule

// File: rtl/synpkt_emitter.sv
module synpkt_emitter
  import synpkt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 12,
  localparam int WORD_W = LANES * PKT_W,
  localparam int SLOT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_first,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              tstep_end,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PKT_W-1:0]  out_data
);

  logic [SLOT_W-1:0] slots_left;
  logic [SLOT_W-1:0] load_slots;
  logic [PKT_W-1:0]  cur_pkt;
  logic              in_neuron;
  logic              more_words;
  logic              glob_pend;

  // Named events, also observed by the checker.
  logic have_pkt, want_local, want_global;
  logic acc_fire, out_fire;
  logic emit_data, emit_local, emit_global;

  assign have_pkt    = (slots_left != '0);
  assign want_local  = in_neuron && !more_words && !have_pkt;
  assign want_global = !in_neuron && glob_pend && !have_pkt;

  assign out_valid = have_pkt || want_local || want_global;
  assign in_ready  = !have_pkt && (in_neuron ? more_words : !glob_pend);

  assign acc_fire    = in_valid && in_ready;
  assign out_fire    = out_valid && out_ready;
  assign emit_data   = out_fire && have_pkt;
  assign emit_local  = out_fire && want_local;
  assign emit_global = out_fire && want_global;

  always_comb begin
    if (have_pkt)         out_data = scrub_data(cur_pkt);
    else if (want_local)  out_data = make_token(SYNC_LOCAL);
    else if (want_global) out_data = make_token(SYNC_GLOBAL);
    else                  out_data = '0;
  end

  synpkt_slot_buf #(
    .LANES (LANES),
    .PKT_W (PKT_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (acc_fire),
    .load_word  (in_data),
    .load_slots (load_slots),
    .pop        (emit_data),
    .slots_left (slots_left),
    .cur_pkt    (cur_pkt)
  );

  synpkt_neuron_trk #(
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (acc_fire),
    .start      (in_first),
    .count      (in_count),
    .local_done (emit_local),
    .glob_req   (tstep_end),
    .glob_done  (emit_global),
    .in_neuron  (in_neuron),
    .more_words (more_words),
    .glob_pend  (glob_pend),
    .load_slots (load_slots)
  );

endmodule

// File: rtl/synpkt_emitter_chk.sv
module synpkt_emitter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        emit_local,
  input logic        emit_global,
  input logic        in_neuron
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R6

  AST_SYNC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[31:30] != 2'b11); // R1

  AST_LOCAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[31:30] == 2'b01 |-> out_data == 64'h0000_0000_4000_0000); // R3

  AST_LOCAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_local |=> !(out_valid && out_data[31:30] == 2'b01)); // R3

  AST_GLOBAL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_global |-> !in_neuron && out_data == 64'h0000_0000_8000_0000); // R4

endmodule

bind synpkt_emitter synpkt_emitter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .emit_local  (emit_local),
  .emit_global (emit_global),
  .in_neuron   (in_neuron)
);

// File: tb/synpkt_emitter_tb.sv
`timescale 1ns/1ps
module synpkt_emitter_tb;

  localparam int CNT_W = 12;
  localparam logic [63:0] LOC_TOK = 64'h0000_0000_4000_0000;
  localparam logic [63:0] GLB_TOK = 64'h0000_0000_8000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_data = '0;
  logic         in_first = 1'b0;
  logic [CNT_W-1:0] in_count = '0;
  logic         tstep_end = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [63:0]  out_data;

  int checks = 0;
  int failures = 0;
  bit rdy_mode = 1'b0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];

  always #2 clk = ~clk;

  synpkt_emitter #(.LANES(4), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_count(in_count),
    .tstep_end(tstep_end), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Raw packet as stored in memory (sync bits deliberately set to 11).
  function automatic logic [63:0] raw_pkt(int seed, int p);
    return {32'(seed * 256 + p), 2'b11, 22'(seed + p * 5), 8'(p + 1)};
  endfunction

  function automatic logic [63:0] exp_pkt(int seed, int p);
    return {32'(seed * 256 + p), 2'b00, 22'(seed + p * 5), 8'(p + 1)};
  endfunction

  // Output side: drive ready, check hold rule, compare handshakes with model.
  initial begin : consumer
    bit hold_prev;
    logic [63:0] hold_data;
    hold_prev = 1'b0;
    hold_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_prev)
          chk(out_valid && out_data == hold_data, "R5 hold", out_data, hold_data);
        out_ready = rdy_mode ? ($urandom % 3 != 0) : 1'b1;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected output", out_data, 64'h0);
          end else begin
            chk(out_data == exp_q[0], "R1 R2 R3 R4 stream order", out_data, exp_q[0]);
            void'(exp_q.pop_front());
          end
        end
        hold_prev = out_valid && !out_ready;
        hold_data = out_data;
      end
    end
  end

  // Offer a word at a falling edge; return at the falling edge after acceptance.
  task automatic push_word(input logic [255:0] d, input bit first, input logic [CNT_W-1:0] cnt);
    in_data  = d;
    in_first = first;
    in_count = cnt;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic pulse_req();
    tstep_end = 1'b1;
    @(negedge clk);
    tstep_end = 1'b0;
  endtask

  // One neuron: model pushed first, then words; optional timestep end after word 0.
  task automatic send_neuron(input int count, input int seed, input bit glob);
    int nwords;
    logic [255:0] w;
    nwords = (count == 0) ? 1 : (count + 3) / 4;
    for (int p = 0; p < count; p++) exp_q.push_back(exp_pkt(seed, p));
    exp_q.push_back(LOC_TOK);
    if (glob) exp_q.push_back(GLB_TOK);
    for (int i = 0; i < nwords; i++) begin
      for (int s = 0; s < 4; s++)
        w[64*s +: 64] = (i * 4 + s < count) ? raw_pkt(seed, i * 4 + s) : 64'hFFFF_FFFF_FFFF_FFFF;
      // R9: continuation words carry a bogus start flag and count.
      push_word(w, 1'b1, (i == 0) ? CNT_W'(count) : CNT_W'(99));
      if (glob && i == 0) pulse_req();
    end
  endtask

  task automatic wait_drain();
    int t;
    t = 0;
    while ((exp_q.size() != 0) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0, "R2 drain", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [255:0] w;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 out_valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R8 in_ready", 64'(in_ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R8 after release", 64'(out_valid), 64'h0);

    // R1 R3 timing probe: four packets on consecutive cycles, then local token.
    for (int p = 0; p < 4; p++) exp_q.push_back(exp_pkt(3, p));
    exp_q.push_back(LOC_TOK);
    for (int s = 0; s < 4; s++) w[64*s +: 64] = raw_pkt(3, s);
    push_word(w, 1'b1, CNT_W'(4));
    for (int c = 0; c < 5; c++) begin
      chk(out_valid == 1'b1, "R1 R3 due cycle valid", 64'(out_valid), 64'h1);
      chk(out_data == ((c < 4) ? exp_pkt(3, c) : LOC_TOK), "R1 R3 due cycle data",
          out_data, (c < 4) ? exp_pkt(3, c) : LOC_TOK);
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R3 single local token", 64'(out_valid), 64'h0);
    wait_drain();

    // R2: zero count consumes a word and yields only the local token.
    exp_q.push_back(LOC_TOK);
    push_word({4{raw_pkt(9, 0)}}, 1'b1, CNT_W'(0));
    chk(out_valid && out_data == LOC_TOK, "R2 zero count", out_data, LOC_TOK);
    wait_drain();

    // R2 R9: counts not multiple of four, multi-word neurons.
    send_neuron(1, 11, 1'b0);
    send_neuron(5, 12, 1'b0);
    send_neuron(8, 13, 1'b0);
    send_neuron(11, 14, 1'b0);
    wait_drain();

    // R7: stray word with no start flag is dropped.
    push_word({4{raw_pkt(20, 1)}}, 1'b0, CNT_W'(4));
    for (int c = 0; c < 4; c++) begin
      chk(out_valid == 1'b0, "R7 stray word silent", 64'(out_valid), 64'h0);
      @(negedge clk);
    end
    chk(in_ready == 1'b1, "R7 ready after stray", 64'(in_ready), 64'h1);

    // R4: idle request gives a global token one cycle after its sampling edge.
    exp_q.push_back(GLB_TOK);
    pulse_req();
    chk(out_valid && out_data == GLB_TOK, "R4 idle global due", out_data, GLB_TOK);
    wait_drain();

    // R4: request during a neuron waits for its local token, precedes next neuron.
    fork
      begin
        send_neuron(6, 21, 1'b1);
        send_neuron(3, 22, 1'b0);
      end
    join
    wait_drain();

    // R5 with irregular ready, mixed counts and timestep ends.
    rdy_mode = 1'b1;
    for (int n = 0; n < 24; n++)
      send_neuron((n * 7 + 3) % 14, 30 + n, (n % 5 == 2));
    exp_q.push_back(GLB_TOK);
    pulse_req();
    wait_drain();
    rdy_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R6 idle at end", 64'(out_valid), 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule